// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands of `OPW` bits (four by default) and returns their full-width product. It is purely combinational: there is no clock, no reset and no stored state, so the product follows its operands once the logic has settled. It is meant as a small arithmetic leaf inside a larger datapath. The surrounding logic must register its inputs and its output as its own timing needs.

Every operand bit pair is ANDed into a partial-product bit. The partial products are then reduced row by row in a carry-save array of half-adder and full-adder cells. No carry moves sideways within a row; each cell passes its carry diagonally to the next row. Each row retires one low product bit. The last sum and carry vectors are merged by a carry-lookahead adder of `OPW` bits, whose carry out is the most significant product bit.

Top module: `cs_array_mult`

## Requirements
- R1: Product bit 0 equals the AND of operand bit 0 of `a_in` and operand bit 0 of `b_in`, with no adder on its path.
- R2: For every pair of unsigned operands, `prod_out` equals the arithmetic product of `a_in` and `b_in` over all `2*OPW` bits.
- R3: When either operand is zero, `prod_out` is zero.
- R4: When one operand equals one, `prod_out` equals the other operand, zero-extended to `2*OPW` bits.
- R5: The largest operands (all ones in both) give the largest product, 8'hE1 for four-bit operands. Its top bit is the carry out of the final adder.
- R6: The upper `OPW+1` product bits are the lookahead sum, and its carry out, of the array's last sum and carry vectors. They equal the true product shifted right by `OPW-1`.
- R7: When one operand is a power of two, 2^k, the product equals the other operand shifted left by k.
- R8: Swapping the two operands leaves the product unchanged.
- R9: The output depends only on the present operands: the same pair gives the same product whatever pairs were applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | OPW | Multiplicand, unsigned |
| b_in | input | OPW | Multiplier, unsigned; bit i selects partial-product row i |
| prod_out | output | 2*OPW | Unsigned product of a_in and b_in |

## Verification
All 256 operand pairs are swept. This is the check that separates a correct cell network from one with a single misrouted carry or a wrong column weight. Directed patterns come before the sweep, and each isolates one part of the structure:
- Zero operands show whether any cell produces a stray one.
- Unit operands and powers of two move a single row of partial products across the array, so a wrong row-to-column alignment shows up as a shifted result.
- The all-ones pair drives every carry in the array and in the lookahead adder, and so exposes a broken carry-out path.
- Swapped operands send the same product through transposed partial products, which tells apart a fault that depends on which operand feeds the rows.
- A repeated pair after unrelated traffic shows that no state has crept in.

// File: rtl/csm_pkg.sv
package csm_pkg;

    localparam int unsigned OPW_DEFAULT = 4;

    // Shift-and-add reference product, used only by assertions.
    function automatic logic [63:0] shift_add_product(
        input logic [31:0] mcand,
        input logic [31:0] mplier,
        input int unsigned width
    );
        logic [63:0] acc_d;
        acc_d = '0;
        for (int unsigned i = 0; i < width; i++) begin
            if (mplier[i]) begin
                acc_d = acc_d + (64'(mcand) << i);
            end
        end
        return acc_d;
    endfunction

endpackage

// File: rtl/csm_half_cell.sv
module csm_half_cell (
    input  logic x_in,
    input  logic y_in,
    output logic sum_out,
    output logic carry_out
);
    always_comb begin
        sum_out   = x_in ^ y_in;
        carry_out = x_in & y_in;
    end
endmodule

// File: rtl/csm_full_cell.sv
module csm_full_cell (
    input  logic x_in,
    input  logic y_in,
    input  logic z_in,
    output logic sum_out,
    output logic carry_out
);
    logic half_d;

    always_comb begin
        half_d    = x_in ^ y_in;
        sum_out   = half_d ^ z_in;
        carry_out = (x_in & y_in) | (half_d & z_in);
    end
endmodule

// File: rtl/csm_cla_adder.sv
module csm_cla_adder #(
    parameter int unsigned AW = 4
) (
    input  logic [AW-1:0] x_in,
    input  logic [AW-1:0] y_in,
    input  logic          cin,
    output logic [AW-1:0] sum_out,
    output logic          cout
);
    logic [AW-1:0] gen_d;
    logic [AW-1:0] prop_d;
    logic [AW:0]   cy_d;

    // Each carry is a flat sum of products of generate, propagate and cin.
    always_comb begin
        logic chain_d;
        logic term_d;
        logic acc_d;
        gen_d   = x_in & y_in;
        prop_d  = x_in ^ y_in;
        cy_d    = '0;
        cy_d[0] = cin;
        for (int k = 1; k <= int'(AW); k++) begin
            chain_d = cin;
            for (int q = 0; q < k; q++) begin
                chain_d = chain_d & prop_d[q];
            end
            acc_d = chain_d;
            for (int m = 0; m < k; m++) begin
                term_d = gen_d[m];
                for (int q = m + 1; q < k; q++) begin
                    term_d = term_d & prop_d[q];
                end
                acc_d = acc_d | term_d;
            end
            cy_d[k] = acc_d;
        end
        sum_out = prop_d ^ cy_d[AW-1:0];
        cout    = cy_d[AW];
    end

    always_comb begin
        assert_cla_sum_R6: assert ({cout, sum_out} ==
            ({1'b0, x_in} + {1'b0, y_in} + (AW+1)'(cin)))
            else $error("lookahead sum differs from operand sum");
    end
endmodule

// File: rtl/csm_array.sv
module csm_array #(
    parameter int unsigned OPW = csm_pkg::OPW_DEFAULT
) (
    input  logic [OPW-1:0] a_in,
    input  logic [OPW-1:0] b_in,
    output logic [OPW-2:0] low_out,
    output logic [OPW-1:0] fin_x_out,
    output logic [OPW-1:0] fin_y_out
);
    localparam int unsigned CELLS = OPW - 1;

    logic [OPW-1:0][OPW-1:0]   pp_d;   // row i: a_in gated by b_in[i]
    logic [OPW-1:0][CELLS-1:0] sum_d;  // per-row sum vector
    logic [OPW-1:1][CELLS-1:0] cry_d;  // per-row carry vector

    for (genvar i = 0; i < int'(OPW); i++) begin : g_pp
        assign pp_d[i] = a_in & {OPW{b_in[i]}};
    end

    // Row 0 is the raw lower partial products of b_in[0].
    assign sum_d[0] = pp_d[0][CELLS-1:0];

    for (genvar i = 1; i < int'(OPW); i++) begin : g_row
        for (genvar j = 0; j < int'(CELLS); j++) begin : g_cell
            logic above_d;
            // Left column takes the previous row's top partial product.
            if (j == int'(CELLS) - 1) begin : g_edge
                assign above_d = pp_d[i-1][OPW-1];
            end else begin : g_inner
                assign above_d = sum_d[i-1][j+1];
            end
            if (i == 1) begin : g_ha
                csm_half_cell u_ha (
                    .x_in      (pp_d[i][j]),
                    .y_in      (above_d),
                    .sum_out   (sum_d[i][j]),
                    .carry_out (cry_d[i][j])
                );
            end else begin : g_fa
                csm_full_cell u_fa (
                    .x_in      (pp_d[i][j]),
                    .y_in      (above_d),
                    .z_in      (cry_d[i-1][j]),
                    .sum_out   (sum_d[i][j]),
                    .carry_out (cry_d[i][j])
                );
            end
        end
    end

    // Each row retires one low product bit.
    for (genvar i = 0; i < int'(CELLS); i++) begin : g_low
        assign low_out[i] = sum_d[i][0];
    end

    assign fin_x_out = {pp_d[OPW-1][OPW-1], sum_d[OPW-1]};
    assign fin_y_out = {cry_d[OPW-1], 1'b0};

    // The retired bits plus the weighted leftover vectors hold the product.
    always_comb begin
        assert_array_total_R2: assert ((64'(low_out) +
            ((64'(fin_x_out) + 64'(fin_y_out)) << (OPW - 1))) ==
            csm_pkg::shift_add_product(32'(a_in), 32'(b_in), OPW))
            else $error("carry-save array lost or misweighted a bit");
    end
endmodule

// File: rtl/cs_array_mult.sv
module cs_array_mult #(
    parameter int unsigned OPW = csm_pkg::OPW_DEFAULT
) (
    input  logic [OPW-1:0]   a_in,
    input  logic [OPW-1:0]   b_in,
    output logic [2*OPW-1:0] prod_out
);
    logic [OPW-2:0] low_d;
    logic [OPW-1:0] fin_x_d;
    logic [OPW-1:0] fin_y_d;
    logic [OPW-1:0] hi_sum_d;
    logic           hi_cout_d;

    csm_array #(.OPW(OPW)) u_array (
        .a_in      (a_in),
        .b_in      (b_in),
        .low_out   (low_d),
        .fin_x_out (fin_x_d),
        .fin_y_out (fin_y_d)
    );

    csm_cla_adder #(.AW(OPW)) u_final (
        .x_in    (fin_x_d),
        .y_in    (fin_y_d),
        .cin     (1'b0),
        .sum_out (hi_sum_d),
        .cout    (hi_cout_d)
    );

    assign prod_out = {hi_cout_d, hi_sum_d, low_d};

    always_comb begin
        assert_lsb_and_R1: assert (prod_out[0] == (a_in[0] & b_in[0]))
            else $error("product bit 0 is not the operand LSB AND");
        if (a_in == '0 || b_in == '0) begin
            assert_zero_operand_R3: assert (prod_out == '0)
                else $error("zero operand gave a nonzero product");
        end
        if (a_in == OPW'(1)) begin
            assert_unit_operand_R4: assert (prod_out == (2*OPW)'(b_in))
                else $error("unit multiplicand did not pass the multiplier");
        end
    end
endmodule

// File: tb/cs_array_mult_tb_top.sv
module cs_array_mult_tb_top;
    localparam int unsigned OPW = 4;
    localparam int unsigned PW  = 2 * OPW;

    logic          clk = 1'b0;
    logic [OPW-1:0] a_r = '0;
    logic [OPW-1:0] b_r = '0;
    logic [PW-1:0]  prod_w;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    cs_array_mult #(.OPW(OPW)) dut_i (
        .a_in     (a_r),
        .b_in     (b_r),
        .prod_out (prod_w)
    );

    task automatic check(input string req, input logic [PW-1:0] got,
                         input logic [PW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: a=%0d b=%0d got %0h expected %0h",
                     req, a_r, b_r, got, exp);
        end
    endtask

    // Drive at the rising edge, sample at the falling edge.
    task automatic apply(input int a, input int b);
        @(posedge clk);
        a_r = OPW'(a);
        b_r = OPW'(b);
        @(negedge clk);
    endtask

    function automatic logic [PW-1:0] expect_prod(input int a, input int b);
        return PW'(a * b);
    endfunction

    task automatic t_idle;
        @(negedge clk);
        check("R3 idle zero", prod_w, '0);
    endtask

    task automatic t_zero;
        for (int v = 0; v < 16; v++) begin
            apply(0, v);
            check("R3 a zero", prod_w, '0);
            apply(v, 0);
            check("R3 b zero", prod_w, '0);
        end
    endtask

    task automatic t_lsb;
        apply(5, 3);
        check("R1 lsb set", {7'b0, prod_w[0]}, 8'd1);
        apply(5, 2);
        check("R1 lsb clear", {7'b0, prod_w[0]}, 8'd0);
    endtask

    task automatic t_unit;
        for (int v = 0; v < 16; v++) begin
            apply(1, v);
            check("R4 a one", prod_w, PW'(v));
            apply(v, 1);
            check("R4 b one", prod_w, PW'(v));
        end
    endtask

    task automatic t_max;
        apply(15, 15);
        check("R5 max product", prod_w, 8'hE1);
        check("R5 top bit", {7'b0, prod_w[PW-1]}, 8'd1);
    endtask

    task automatic t_pow2;
        for (int k = 0; k < 4; k++) begin
            for (int v = 0; v < 16; v++) begin
                apply(1 << k, v);
                check("R7 power of two", prod_w, PW'(v << k));
            end
        end
    endtask

    task automatic t_swap;
        logic [PW-1:0] first;
        for (int a = 0; a < 16; a += 3) begin
            for (int b = a + 1; b < 16; b += 5) begin
                apply(a, b);
                first = prod_w;
                apply(b, a);
                check("R8 swapped operands", prod_w, first);
            end
        end
    endtask

    task automatic t_history;
        apply(11, 13);
        check("R9 first visit", prod_w, expect_prod(11, 13));
        apply(15, 15);
        apply(0, 9);
        apply(7, 6);
        apply(11, 13);
        check("R9 revisit", prod_w, expect_prod(11, 13));
    endtask

    task automatic t_sweep;
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                apply(a, b);
                check("R2 full product", prod_w, expect_prod(a, b));
                check("R6 upper bits", PW'(prod_w >> (OPW - 1)),
                      PW'(expect_prod(a, b) >> (OPW - 1)));
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_idle();
        t_zero();
        t_lsb();
        t_unit();
        t_max();
        t_pow2();
        t_swap();
        t_history();
        t_sweep();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule